// File: doc/BRIEF.md
# Register File with Shadow Low Bank

This block is a general register file with 32 entries of 32 bits. It has two combinational read ports and one write port. A second, small bank of four shadow registers sits beside the main array. A mode input, `shadow_mode`, is driven from the temporary-remap bit of the machine state register. While that input is high, every access to register numbers 0 to 3 is steered to the shadow register with the same number. A translation-miss handler can then use four scratch registers without saving the interrupted context's low registers.

The remap bit is raised when an instruction-fetch translation miss or a data load/store translation miss is taken. It is dropped by the return-from-interrupt. This block only follows the level of the input. Bank choice is made fresh in every cycle from the input's current value. Handler code is not expected to touch register numbers 4 to 31 while the mode is set. The block flags any such access and defines it as follows: a write there is discarded, and a read there returns the main array.

Top module: `tgpr_regfile`

## Requirements
- R1: With `shadow_mode`=1, a read or write of index 0–3 targets shadow register 0–3 of the same index.
- R2: With `shadow_mode`=1, main registers 0–3 keep their contents whatever is written.
- R3: `bad_access` is high, in the same cycle, exactly when `shadow_mode`=1 and at least one enabled access (`ra_en`, `rb_en` or `wr_en`) uses an index of 4 or above. It is low otherwise.
- R4: With `shadow_mode`=1, a write to index 4–31 changes no register. A read of index 4–31 returns the main register.
- R5: With `shadow_mode`=0, indices 0–3 target the main registers. The shadow registers are neither read nor written.
- R6: A read of the index being written in the same cycle returns the old value. The new value is readable from the next cycle.
- R7: After reset every main and shadow register reads 0.
- R8: Shadow registers keep their values across any number of mode changes.
- R9: Bank choice for each access follows `shadow_mode` in that same cycle, including when the mode toggles between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| shadow_mode | input | 1 | Remap low indices to shadow bank |
| ra_en | input | 1 | Port A read is in use |
| ra_idx | input | 5 | Port A register index |
| ra_data | output | 32 | Port A read data |
| rb_en | input | 1 | Port B read is in use |
| rb_idx | input | 5 | Port B register index |
| rb_data | output | 32 | Port B read data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| bad_access | output | 1 | Upper-index access while in shadow mode |

## Verification
A write steered to the wrong bank stays hidden until the same index is read back. For that reason the bench reads every written index in the next cycle, and again after toggling the mode, on both banks. A corrupted main low register or shadow register would otherwise only show up when the handler returns. The bench therefore writes in one mode and checks the other bank right after the switch. The flag is combinational, so a wrong flag decode shows in the cycle of the access.

// File: rtl/tgpr_regfile.sv
module tgpr_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int NTMP = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shadow_mode,
  input  logic                    ra_en,
  input  logic [$clog2(NREG)-1:0] ra_idx,
  output logic [DW-1:0]           ra_data,
  input  logic                    rb_en,
  input  logic [$clog2(NREG)-1:0] rb_idx,
  output logic [DW-1:0]           rb_data,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DW-1:0]           wr_data,
  output logic                    bad_access
);
  localparam int AW = $clog2(NREG);
  localparam int TW = $clog2(NTMP);

  logic [NREG-1:0][DW-1:0] gpr;
  logic [NTMP-1:0][DW-1:0] tmp;

  logic ra_low, rb_low, wr_low;
  assign ra_low = int'(ra_idx) < NTMP;
  assign rb_low = int'(rb_idx) < NTMP;
  assign wr_low = int'(wr_idx) < NTMP;

  logic wr_tmp, wr_gpr;
  assign wr_tmp = wr_en & shadow_mode & wr_low;
  assign wr_gpr = wr_en & ~shadow_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpr <= '0;
      tmp <= '0;
    end else begin
      if (wr_gpr) gpr[wr_idx] <= wr_data;
      if (wr_tmp) tmp[wr_idx[TW-1:0]] <= wr_data;
    end
  end

  assign ra_data = (shadow_mode && ra_low) ? tmp[ra_idx[TW-1:0]] : gpr[ra_idx];
  assign rb_data = (shadow_mode && rb_low) ? tmp[rb_idx[TW-1:0]] : gpr[rb_idx];

  assign bad_access = shadow_mode & ((ra_en & ~ra_low) | (rb_en & ~rb_low) | (wr_en & ~wr_low));

  AST_LOW_MAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_mode |=> $stable(gpr[NTMP-1:0])); // R2
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_mode |=> $stable(tmp)); // R5
  AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_mode && wr_en && wr_low) |=> tmp[$past(wr_idx[TW-1:0])] == $past(wr_data)); // R1
  AST_UPPER_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_mode && wr_en && !wr_low) |=> ($stable(gpr) && $stable(tmp))); // R4
  AST_FLAG_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> shadow_mode); // R3
  AST_MAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_mode && wr_en) |=> gpr[$past(wr_idx)] == $past(wr_data)); // R5
endmodule

// File: tb/sim_tgpr_regfile.sv
module sim_tgpr_regfile;
  logic clk = 0, rst_n = 0, shadow_mode = 0;
  logic ra_en = 0, rb_en = 0, wr_en = 0;
  logic [4:0] ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic [31:0] wr_data = 0, ra_data, rb_data;
  logic bad_access;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tgpr_regfile u0 (.clk, .rst_n, .shadow_mode, .ra_en, .ra_idx, .ra_data,
    .rb_en, .rb_idx, .rb_data, .wr_en, .wr_idx, .wr_data, .bad_access);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit mode, logic [4:0] idx, logic [31:0] d);
    @(negedge clk);
    shadow_mode = mode; wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(bit mode, logic [4:0] idx, output logic [31:0] d);
    @(negedge clk);
    shadow_mode = mode; ra_en = 1; ra_idx = idx;
    #1 d = ra_data;
    ra_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 32; i++) begin rd(0, 5'(i), d); check("R7 main", d, 0); end
    for (int i = 0; i < 4; i++) begin rd(1, 5'(i), d); check("R7 shadow", d, 0); end
    check("R7 flag", bad_access, 0);
  endtask

  task automatic t_normal();
    logic [31:0] d;
    for (int i = 0; i < 32; i++) wr(0, 5'(i), 32'h1000_0000 + i);
    for (int i = 0; i < 32; i++) begin rd(0, 5'(i), d); check("R5 main", d, 32'h1000_0000 + i); end
    for (int i = 0; i < 4; i++) begin rd(1, 5'(i), d); check("R5 shadow untouched", d, 0); end
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) wr(1, 5'(i), 32'hA5A5_0000 + i);
    for (int i = 0; i < 4; i++) begin rd(1, 5'(i), d); check("R1 shadow", d, 32'hA5A5_0000 + i); end
    for (int i = 0; i < 4; i++) begin rd(0, 5'(i), d); check("R2 main low held", d, 32'h1000_0000 + i); end
    @(negedge clk);
    shadow_mode = 1; rb_en = 1; rb_idx = 3;
    #1 check("R1 port B", rb_data, 32'hA5A5_0003);
    rb_en = 0;
  endtask

  task automatic t_upper();
    logic [31:0] d;
    @(negedge clk);
    shadow_mode = 1; wr_en = 1; wr_idx = 9; wr_data = 32'hDEAD_BEEF;
    #1 check("R3 flag write", bad_access, 1);
    @(negedge clk);
    wr_en = 0;
    rd(0, 9, d); check("R4 upper write dropped", d, 32'h1000_0009);
    rd(1, 9, d); check("R4 upper read main", d, 32'h1000_0009);
    @(negedge clk);
    shadow_mode = 1; rb_en = 1; rb_idx = 31;
    #1 check("R3 flag read B", bad_access, 1);
    rb_en = 0; ra_en = 1; ra_idx = 2;
    #1 check("R3 flag low index", bad_access, 0);
    ra_idx = 4;
    #1 check("R3 flag index 4", bad_access, 1);
    shadow_mode = 0;
    #1 check("R3 flag mode off", bad_access, 0);
    ra_en = 0; ra_idx = 31; shadow_mode = 1;
    #1 check("R3 flag disabled port", bad_access, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    shadow_mode = 0; wr_en = 1; wr_idx = 7; wr_data = 32'h7777_7777; ra_idx = 7;
    #1 check("R6 old value", ra_data, 32'h1000_0007);
    @(negedge clk);
    wr_en = 0;
    #1 check("R6 new value", ra_data, 32'h7777_7777);
    shadow_mode = 1; wr_en = 1; wr_idx = 1; wr_data = 32'h1111_1111; ra_idx = 1;
    #1 check("R6 shadow old", ra_data, 32'hA5A5_0001);
    @(negedge clk);
    wr_en = 0;
    #1 check("R6 shadow new", ra_data, 32'h1111_1111);
  endtask

  task automatic t_toggle();
    logic [31:0] d;
    wr(1, 0, 32'hCAFE_0000);
    wr(0, 0, 32'hBEEF_0000);
    for (int k = 0; k < 3; k++) begin
      rd(1, 0, d); check("R8 shadow retained", d, 32'hCAFE_0000);
      rd(0, 0, d); check("R9 main per cycle", d, 32'hBEEF_0000);
    end
    rd(1, 2, d); check("R8 shadow 2 retained", d, 32'hA5A5_0002);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_normal();
    t_shadow();
    t_upper();
    t_same_cycle();
    t_toggle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule